// File: doc/BRIEF.md
# Strap-Configured Stereo Audio Serial Transmitter

This block puts a stereo pair of 24-bit two's complement samples onto one serial data line, one pair per frame. The bit clock and the word-select (left/right) clock come in as plain inputs. They are oversampled by the block's own system clock, so they may be produced locally or received from another device. An upstream producer writes a new left/right pair with a single-cycle load strobe.

The serial format is not set by any control input. For a fixed number of system clock cycles after reset, the data pin is left undriven. During that window the block reads the level sensed on the pin, which a board resistor pulls high or low. A high level selects the I2S format and a low level selects left-justified. The choice is frozen at the end of the window and the pin then becomes an active output. Frames of 48 or 64 bit clocks are accepted without any setting, because each half-frame is timed purely from word-select transitions.

Top module: `strap_ser_tx`

## Requirements
- R1: Both `sdoOut` and `sdoOe` are 0 while reset is asserted.
- R2: After reset is released, `sdoOe` stays 0 for exactly STRAP_CYC system clock cycles, then goes to 1 and stays at 1 until the next reset.
- R3: `strapIn` is sampled on the last cycle of that window: 1 selects I2S and 0 selects left-justified. Changes to `strapIn` after that cycle have no effect on the format.
- R4: Each 24-bit channel word is sent most significant bit first, from bit 23 down to bit 0, exactly as loaded (two's complement is passed through unchanged).
- R5: In left-justified format, the MSB is driven in the bit slot that begins at the bit-clock falling edge coinciding with the word-select change, and word-select high marks the left channel.
- R6: In I2S format, the MSB is driven one bit slot after the word-select change, and word-select low marks the left channel.
- R7: Every bit slot that carries no word bit is driven as 0.
- R8: Half-frames of 24 and 32 bit slots both work. In I2S with 24-slot halves, the LSB of a word falls into slot 0 of the following half-frame.
- R9: The sample pair is captured at the start of the left half-frame, so a load made later in that frame changes nothing until the next frame.
- R10: `sdoOut` changes only on the system clock edge that follows detection of a bit-clock falling edge; it holds steady at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial clocks |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Bit clock |
| lrckIn | input | 1 | Word-select clock; its level marks the channel |
| leftIn | input | 24 | Left sample to load |
| rightIn | input | 24 | Right sample to load |
| loadStb | input | 1 | One-cycle strobe that stores leftIn/rightIn as the pending pair |
| strapIn | input | 1 | Level sensed on the data pin during the strap window |
| sdoOut | output | 1 | Serial data |
| sdoOe | output | 1 | Output enable for the data pin driver |

## Verification
The bit clock and word select are registered once, and a falling edge is recognised one cycle after that. As a result, `sdoOut` moves two system clock edges after the bench drops the bit clock. The bench holds each bit-clock phase for four system cycles and reads the data only at the following bit-clock rising edge, after the value has settled. The output enable is checked one cycle before and exactly at the end of the strap window, STRAP_CYC cycles after release. Expected words are queued at the moment the bench opens a left half-frame. The I2S 48-slot case needs one extra half-frame opening before its final LSB comes out, so the bench supplies it before checking that the queue is empty.

// File: rtl/strap_ser_pkg.sv
package strap_ser_pkg;
  localparam int unsigned WORD_W = 24;

  typedef logic [WORD_W-1:0] sample_t;

  // strobes from control to datapath, valid for one clk cycle
  typedef struct packed {
    logic bitStep;    // bit-clock falling edge seen while active
    logic halfStart;  // that edge also opens a new half-frame
    logic leftHalf;   // the half-frame being opened is the left channel
    logic fmtI2s;     // latched format: 1 = I2S, 0 = left-justified
  } ser_stb_t;
endpackage

// File: rtl/strap_ser_ctrl.sv
module strap_ser_ctrl
  import strap_ser_pkg::*;
#(
  parameter int unsigned STRAP_CYC = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclkIn,
  input  logic     lrckIn,
  input  logic     strapIn,
  output ser_stb_t stb,
  output logic     active
);
  localparam int unsigned CNT_W = $clog2(STRAP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STRAP_CYC - 1);

  logic sclkQ, sclkPrev, lrckQ, lrckPrev;
  logic [CNT_W-1:0] strapCnt;
  logic fmtI2s;
  logic fallSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      sclkPrev <= 1'b0;
      lrckQ    <= 1'b0;
      lrckPrev <= 1'b0;
    end else begin
      sclkQ    <= sclkIn;
      sclkPrev <= sclkQ;
      lrckQ    <= lrckIn;
      lrckPrev <= lrckQ;
    end
  end

  // strap window: pin undriven, format sampled on its final cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strapCnt <= '0;
      active   <= 1'b0;
      fmtI2s   <= 1'b0;
    end else if (!active) begin
      strapCnt <= strapCnt + 1'b1;
      if (strapCnt == LAST_CNT) begin
        active <= 1'b1;
        fmtI2s <= strapIn;
      end
    end
  end

  assign fallSeen = sclkPrev & ~sclkQ;

  always_comb begin
    stb.bitStep   = fallSeen & active;
    stb.halfStart = fallSeen & active & (lrckQ ^ lrckPrev);
    stb.leftHalf  = fmtI2s ? ~lrckQ : lrckQ;
    stb.fmtI2s    = fmtI2s;
  end
endmodule

// File: rtl/strap_ser_dpath.sv
module strap_ser_dpath
  import strap_ser_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  sample_t  leftIn,
  input  sample_t  rightIn,
  input  logic     loadStb,
  input  ser_stb_t stb,
  output logic     sdoOut
);
  localparam int unsigned SH_W = WORD_W + 1;

  sample_t pendL, pendR, heldR, word;
  logic [SH_W-1:0] shReg;

  always_comb word = stb.leftHalf ? pendL : heldR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendL  <= '0;
      pendR  <= '0;
      heldR  <= '0;
      shReg  <= '0;
      sdoOut <= 1'b0;
    end else begin
      if (loadStb) begin
        pendL <= leftIn;
        pendR <= rightIn;
      end
      if (stb.bitStep) begin
        if (stb.halfStart) begin
          if (stb.leftHalf) heldR <= pendR;
          if (stb.fmtI2s) begin
            // slot 0 carries whatever spilled from the previous word
            sdoOut <= shReg[SH_W-1];
            shReg  <= {word, 1'b0};
          end else begin
            sdoOut <= word[WORD_W-1];
            shReg  <= {word[WORD_W-2:0], 2'b00};
          end
        end else begin
          sdoOut <= shReg[SH_W-1];
          shReg  <= {shReg[SH_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/strap_ser_tx.sv
module strap_ser_tx
  import strap_ser_pkg::*;
#(
  parameter int unsigned STRAP_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              lrckIn,
  input  logic [WORD_W-1:0] leftIn,
  input  logic [WORD_W-1:0] rightIn,
  input  logic              loadStb,
  input  logic              strapIn,
  output logic              sdoOut,
  output logic              sdoOe
);
  ser_stb_t stb;

  strap_ser_ctrl #(.STRAP_CYC(STRAP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lrckIn(lrckIn),
    .strapIn(strapIn), .stb(stb), .active(sdoOe)
  );

  strap_ser_dpath u_dpath (
    .clk(clk), .rstN(rstN), .leftIn(leftIn), .rightIn(rightIn),
    .loadStb(loadStb), .stb(stb), .sdoOut(sdoOut)
  );
endmodule

// File: rtl/strap_ser_tx_chk.sv
module strap_ser_tx_chk #(
  parameter int unsigned STRAP_CYC = 16
) (
  input logic clk,
  input logic rstN,
  input logic sdoOut,
  input logic sdoOe,
  input logic bitStep,
  input logic fmtI2s
);
  localparam int unsigned CW = $clog2(STRAP_CYC + 2);
  logic [CW-1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst < CW'(STRAP_CYC + 1)) sinceRst <= sinceRst + 1'b1;
  end

  // R2
  strap_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < CW'(STRAP_CYC)) |-> !sdoOe);

  // R2
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |=> sdoOe);

  // R3
  fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && $past(sdoOe)) |-> $stable(fmtI2s));

  // R10
  edge_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdoOut) |-> $past(bitStep));

  // R1
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoOe |-> !sdoOut);
endmodule

bind strap_ser_tx strap_ser_tx_chk #(.STRAP_CYC(STRAP_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .sdoOut(sdoOut), .sdoOe(sdoOe),
  .bitStep(stb.bitStep), .fmtI2s(stb.fmtI2s)
);

// File: tb/sim_strap_ser_tx.sv
module sim_strap_ser_tx;
  localparam int STRAP = 16;
  localparam int HALF  = 4;

  logic clk = 0, rstN = 0, sclk = 1, lrck = 0, loadStb = 0, strap = 0;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic sdoOut, sdoOe;

  int checks = 0, errors = 0;
  logic [24:0] expQ[$];
  logic [23:0] benchL, benchR;

  // monitor state
  logic monEn = 0, fmtB = 0, prevL = 0, collecting = 0, chanB = 0;
  int slot = 0, cnt = 0;
  logic [23:0] acc;

  always #4 clk = ~clk;

  strap_ser_tx #(.STRAP_CYC(STRAP)) u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .lrckIn(lrck),
    .leftIn(leftIn), .rightIn(rightIn), .loadStb(loadStb),
    .strapIn(strap), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: rebuild words at bit-clock rising edges
  always @(posedge sclk) begin
    if (monEn) begin
      logic [24:0] e;
      if (lrck != prevL) slot = 0; else slot++;
      prevL = lrck;
      if (slot == (fmtB ? 1 : 0)) begin
        collecting = 1; cnt = 0; acc = '0;
        chanB = fmtB ? ~lrck : lrck;
      end
      if (collecting) begin
        acc = {acc[22:0], sdoOut};
        cnt++;
        if (cnt == 24) begin
          collecting = 0;
          if (expQ.size() == 0) check(0, "R9 unexpected word", acc, 0);
          else begin
            e = expQ.pop_front();
            // R4 R5 R6 R8: word bits and channel
            check({chanB, acc} == e, fmtB ? "R6/R4 word" : "R5/R4 word",
                  {chanB, acc}, e);
          end
        end
      end else begin
        // R7
        check(sdoOut == 1'b0, "R7 fill", sdoOut, 0);
      end
    end
  end

  task automatic loadPair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk); leftIn = l; rightIn = r; loadStb = 1;
    @(negedge clk); loadStb = 0;
    benchL = l; benchR = r;
  endtask

  task automatic frame(input int slots, input bit mid,
                       input logic [23:0] ml, input logic [23:0] mr);
    logic leftLvl = fmtB ? 1'b0 : 1'b1;
    for (int h = 0; h < 2; h++) begin
      for (int s = 0; s < slots/2; s++) begin
        @(negedge clk); sclk = 0;
        if (s == 0) lrck = (h == 0) ? leftLvl : ~leftLvl;
        if (h == 0 && s == 0) begin
          expQ.push_back({1'b1, benchL});
          expQ.push_back({1'b0, benchR});
        end
        for (int k = 1; k < HALF; k++) begin
          @(negedge clk);
          if (mid && h == 0 && s == 6 && k == 1) begin
            leftIn = ml; rightIn = mr; loadStb = 1;
          end else loadStb = 0;
        end
        if (mid && h == 0 && s == 6) begin benchL = ml; benchR = mr; end
        @(negedge clk); sclk = 1; loadStb = 0;
        for (int k = 1; k < HALF; k++) @(negedge clk);
      end
    end
  endtask

  task automatic flushHalf();
    @(negedge clk); sclk = 0; lrck = fmtB ? 1'b0 : 1'b1;
    repeat (HALF-1) @(negedge clk);
    @(negedge clk); sclk = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic phase(input bit i2s, input int slots);
    monEn = 0;
    @(negedge clk);
    rstN = 0; strap = i2s; fmtB = i2s; sclk = 1;
    lrck = i2s ? 1'b1 : 1'b0;   // idle on the right-channel level
    prevL = lrck; collecting = 0; slot = 0;
    expQ.delete();
    repeat (3) @(negedge clk);
    check(sdoOut == 0 && sdoOe == 0, "R1 reset", {sdoOe, sdoOut}, 0);
    rstN = 1;
    repeat (STRAP-1) @(negedge clk);
    check(sdoOe == 0, "R2 window", sdoOe, 0);
    @(negedge clk);
    check(sdoOe == 1, "R2 enable", sdoOe, 1);
    strap = ~i2s;  // R3: must be ignored from here on
    monEn = 1;
    loadPair(24'h800001, 24'h7FFFFE);
    frame(slots, 0, '0, '0);
    loadPair(24'hA5C3F0, 24'h0F1E2D);
    frame(slots, 1, 24'h123456, 24'hFEDCBA);  // R9 mid-frame load
    frame(slots, 0, '0, '0);
    if (i2s) flushHalf();  // R8 releases a spilled LSB
    check(expQ.size() == 0 && !collecting, "R8/R9 drained", expQ.size(), 0);
    check(sdoOe == 1, "R2 stays", sdoOe, 1);
  endtask

  initial begin
    phase(0, 64);
    phase(0, 48);
    phase(1, 64);
    phase(1, 48);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule